// File: doc/BRIEF.md
# Relative Branch Cycle Sequencer

This block runs the bus cycles of a relative-branch instruction in an 8-bit processor with a 16-bit address space. The main controller fetches the opcode and then starts the sequencer. The start request carries the program counter, which already points at the offset byte, together with a flag-select code, a sense bit and the current status flags. From then on the sequencer owns the bus, with exactly one read per enabled clock.

It first fetches the signed offset and steps the program counter. If the condition does not hold, that fetch is the last access. A taken branch that stays inside the 256-byte page costs one more access: a throw-away read at the stepped counter, after which the target is loaded. During that access the block also tells the interrupt logic to recognise pending requests one cycle later. A taken branch that lands on a different page costs two more accesses. The second of these is a throw-away read at the target with its upper byte off by one page, one page above for a backward branch and one page below for a forward one.

A `done` pulse on the final access hands the bus back to the main controller. The new program counter then appears on `pcOut`.

Top module: `branch_timing_seq`

## Requirements
- R1: A start request is taken only while the block is idle and `clkEn` is high. The first access after it is a read at the `pcIn` value captured with the request.
- R2: The flag vector is laid out as bit 0 carry, bit 1 zero, bit 2 overflow, bit 3 negative. `condSel` picks the bit, and the branch is taken exactly when that bit equals `condSense`.
- R3: A branch that is not taken makes one access (the offset fetch) and asserts `done` on it. Afterwards `pcOut` equals `pcIn`+1 modulo 2^16.
- R4: The target of a taken branch is `pcIn`+1 plus the offset byte read as a two's-complement value, modulo 2^16. `pcOut` holds that target once the branch has finished.
- R5: When the target's upper byte matches that of `pcIn`+1, a taken branch makes two accesses. The second is a read at `pcIn`+1, and `done` is asserted on it.
- R6: `irqDelay` is high only on the final enabled access of a taken branch that stays on its page, and on no other cycle.
- R7: When the target's upper byte differs from that of `pcIn`+1, the branch makes three accesses: `pcIn`, then `pcIn`+1, then the target plus 0x100 if offset bit 7 is set or the target minus 0x100 if it is clear. `done` is asserted on the third access.
- R8: While `clkEn` is low the sequence does not advance, `busAddr` holds its value, and `done` and `irqDelay` stay low.
- R9: `busRead` is high exactly while a branch is in progress. A start request made during that time has no effect on the accesses or on the result.
- R10: `done` marks a single enabled access per branch, and the block is idle on the cycle after it.
- R11: After reset the block is idle with `busRead`, `done` and `irqDelay` low and `pcOut` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Access enable; one bus access per enabled cycle |
| start | input | 1 | Begin a branch (used only when idle) |
| pcIn | input | 16 | Program counter pointing at the offset byte |
| condSel | input | 2 | Index of the flag to test |
| condSense | input | 1 | Flag value that makes the branch taken |
| flags | input | 4 | Status flags {negative, overflow, zero, carry} |
| busDataIn | input | 8 | Read data from the bus |
| busAddr | output | 16 | Address of the current access |
| busRead | output | 1 | High while the block drives a read |
| pcOut | output | 16 | Program counter register |
| done | output | 1 | Final access of the branch |
| irqDelay | output | 1 | Postpone interrupt recognition by one cycle |

## Verification
The bench uses the default 16-bit address and 8-bit offset. At that size the full offset range fits in one sweep. Every one of the 256 offsets is run from a set of starting addresses chosen to sit at page edges, including the top of the address space where the counter wraps. That covers both directions of page crossing, the one-byte cases on either side of a boundary, and same-page targets. All four flags are swept in both senses and under every flag pattern. A few runs stall on every other cycle while holding a competing start request, to exercise the hold and busy behaviour.

// File: rtl/brseq_pkg.sv
package brseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SAME,
    ST_CROSS1,
    ST_CROSS2
  } seqState_t;

  typedef enum logic {
    ADDR_PC,
    ADDR_FIX
  } addrSel_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic     loadPc;     // capture pcIn at start
    logic     stepPc;     // offset fetch completes: pc+1, target computed
    logic     takeTarget; // pc <= target
    addrSel_t addrSel;    // bus address source
  } dpStrobe_t;

endpackage

// File: rtl/brseq_ctrl.sv
module brseq_ctrl
  import brseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       start,
  input  logic [1:0] condSel,
  input  logic       condSense,
  input  logic [3:0] flags,
  input  logic       samePage,
  output dpStrobe_t  strobe,
  output logic       busRead,
  output logic       done,
  output logic       irqDelay
);

  seqState_t stateQ, stateD;
  logic      takenQ, takenD;
  logic      lastCycle;
  logic      sameCycle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      takenQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      takenQ <= takenD;
    end
  end

  always_comb begin
    stateD    = stateQ;
    takenD    = takenQ;
    strobe    = '{loadPc: 1'b0, stepPc: 1'b0, takeTarget: 1'b0, addrSel: ADDR_PC};
    busRead   = 1'b1;
    lastCycle = 1'b0;
    sameCycle = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        busRead = 1'b0;
        if (start && clkEn) begin
          strobe.loadPc = 1'b1;
          takenD        = (flags[condSel] == condSense);
          stateD        = ST_FETCH;
        end
      end
      ST_FETCH: begin
        lastCycle = !takenQ;
        if (clkEn) begin
          strobe.stepPc = 1'b1;
          if (!takenQ)       stateD = ST_IDLE;
          else if (samePage) stateD = ST_SAME;
          else               stateD = ST_CROSS1;
        end
      end
      ST_SAME: begin
        lastCycle = 1'b1;
        sameCycle = 1'b1;
        if (clkEn) begin
          strobe.takeTarget = 1'b1;
          stateD            = ST_IDLE;
        end
      end
      ST_CROSS1: begin
        if (clkEn) begin
          strobe.takeTarget = 1'b1;
          stateD            = ST_CROSS2;
        end
      end
      ST_CROSS2: begin
        lastCycle      = 1'b1;
        strobe.addrSel = ADDR_FIX;
        if (clkEn) stateD = ST_IDLE;
      end
      default: begin
        busRead = 1'b0;
        stateD  = ST_IDLE;
      end
    endcase
  end

  assign done     = lastCycle && clkEn;
  assign irqDelay = sameCycle && clkEn;

endmodule

// File: rtl/brseq_dpath.sv
module brseq_dpath
  import brseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] pcOut,
  output logic              samePage
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pcQ, tgtQ;
  logic              backQ;
  logic [ADDR_W-1:0] pcInc, offExt, tgtComb;
  logic [HI_W-1:0]   hiFix;

  assign pcInc    = pcQ + ADDR_W'(1);
  assign offExt   = {{HI_W{busDataIn[DATA_W-1]}}, busDataIn};
  assign tgtComb  = pcInc + offExt;
  assign samePage = (tgtComb[ADDR_W-1:DATA_W] == pcInc[ADDR_W-1:DATA_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ   <= '0;
      tgtQ  <= '0;
      backQ <= 1'b0;
    end else begin
      if (strobe.loadPc) begin
        pcQ <= pcIn;
      end else if (strobe.stepPc) begin
        pcQ   <= pcInc;
        tgtQ  <= tgtComb;
        backQ <= busDataIn[DATA_W-1];
      end else if (strobe.takeTarget) begin
        pcQ <= tgtQ;
      end
    end
  end

  // Wrong-page address: backward branches read one page up, forward one page down
  assign hiFix = backQ ? pcQ[ADDR_W-1:DATA_W] + HI_W'(1)
                       : pcQ[ADDR_W-1:DATA_W] - HI_W'(1);

  assign busAddr = (strobe.addrSel == ADDR_FIX) ? {hiFix, pcQ[DATA_W-1:0]} : pcQ;
  assign pcOut   = pcQ;

endmodule

// File: rtl/branch_timing_seq.sv
module branch_timing_seq
  import brseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              start,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [1:0]        condSel,
  input  logic              condSense,
  input  logic [3:0]        flags,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRead,
  output logic [ADDR_W-1:0] pcOut,
  output logic              done,
  output logic              irqDelay
);

  dpStrobe_t strobe;
  logic      samePage;

  brseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clkEn     (clkEn),
    .start     (start),
    .condSel   (condSel),
    .condSense (condSense),
    .flags     (flags),
    .samePage  (samePage),
    .strobe    (strobe),
    .busRead   (busRead),
    .done      (done),
    .irqDelay  (irqDelay)
  );

  brseq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pcIn      (pcIn),
    .busDataIn (busDataIn),
    .busAddr   (busAddr),
    .pcOut     (pcOut),
    .samePage  (samePage)
  );

endmodule

// File: rtl/brseq_checker.sv
module brseq_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              start,
  input logic [ADDR_W-1:0] pcIn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic [ADDR_W-1:0] pcOut,
  input logic              done,
  input logic              irqDelay
);

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !clkEn) |=> (busRead && $stable(busAddr))); // R8

  AST_IRQ_SAME_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    irqDelay |=> (pcOut[ADDR_W-1:DATA_W] == $past(busAddr[ADDR_W-1:DATA_W]))); // R6

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busRead); // R10

  AST_START_READS_PCIN: assert property (@(posedge clk) disable iff (!rstN)
    (start && clkEn && !busRead) |=> (busRead && busAddr == $past(pcIn))); // R1

  AST_DONE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busRead && clkEn)); // R9

endmodule

bind branch_timing_seq brseq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_branch_timing_seq.sv
module tb_branch_timing_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic        start = 1'b0;
  logic [15:0] pcIn = '0;
  logic [1:0]  condSel = '0;
  logic        condSense = 1'b0;
  logic [3:0]  flags = '0;
  logic [7:0]  busDataIn = '0;
  logic [15:0] busAddr;
  logic        busRead;
  logic [15:0] pcOut;
  logic        done;
  logic        irqDelay;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  branch_timing_seq dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .start(start), .pcIn(pcIn),
    .condSel(condSel), .condSense(condSense), .flags(flags),
    .busDataIn(busDataIn), .busAddr(busAddr), .busRead(busRead),
    .pcOut(pcOut), .done(done), .irqDelay(irqDelay)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic runBranch(input logic [15:0] pc, input logic [7:0] off,
                           input logic [1:0] sel, input logic sense,
                           input logic [3:0] fl, input bit stall);
    logic [15:0] inc, tgt, expPc;
    logic [15:0] expA [3];
    int nAcc, irqIdx, n, guard;
    bit taken, phase;
    taken   = (fl[sel] == sense);          // R2
    inc     = pc + 16'd1;
    tgt     = inc + {{8{off[7]}}, off};    // R4
    expA[0] = pc;
    expA[1] = inc;
    expA[2] = off[7] ? tgt + 16'h0100 : tgt - 16'h0100;
    irqIdx  = -1;
    if (!taken) begin
      nAcc = 1; expPc = inc;
    end else if (tgt[15:8] == inc[15:8]) begin
      nAcc = 2; expPc = tgt; irqIdx = 1;
    end else begin
      nAcc = 3; expPc = tgt;
    end

    @(negedge clk);
    start = 1'b1; pcIn = pc; condSel = sel; condSense = sense;
    flags = fl; busDataIn = off; clkEn = 1'b1;
    n = 0; guard = 0; phase = 1'b0;
    while (n < nAcc && guard < 20) begin
      @(negedge clk);
      start = stall;
      if (stall) pcIn = ~pc;
      clkEn = stall ? phase : 1'b1;
      phase = ~phase;
      #1;
      check(busRead && busAddr == expA[n],
            (n == 0) ? "R1 offset fetch address" : (n == 1) ? "R5 second access address"
                                                             : "R7 wrong-page address",
            int'(busAddr), int'(expA[n]));
      if (clkEn) begin
        check(done == (n == nAcc - 1), taken ? "R10 done on final access" : "R3 not-taken done",
              int'(done), int'(n == nAcc - 1));
        check(irqDelay == (n == irqIdx), "R6 irqDelay", int'(irqDelay), int'(n == irqIdx));
        n++;
      end else begin
        check(!done && !irqDelay, "R8 stalled cycle outputs", int'({done, irqDelay}), 0);
      end
      guard++;
    end
    @(negedge clk);
    start = 1'b0; clkEn = 1'b1;
    #1;
    check(!busRead, "R9 idle after branch", int'(busRead), 0);
    check(pcOut == expPc, taken ? "R4 target pc" : "R3 stepped pc", int'(pcOut), int'(expPc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [7];
    bases = '{16'h1000, 16'h10FD, 16'h1080, 16'h10FE, 16'hFFF0, 16'h00FF, 16'hFFFF};
    repeat (3) @(negedge clk);
    #1;
    check(!busRead && !done && !irqDelay && pcOut == 16'h0,
          "R11 reset state", int'({busRead, done, irqDelay}), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 and R3: every flag, both senses, all flag patterns
    for (int s = 0; s < 4; s++)
      for (int sn = 0; sn < 2; sn++)
        for (int f = 0; f < 16; f++)
          runBranch(16'h2040 + 16'(f), 8'(f * 13), 2'(s), sn[0], 4'(f), 1'b0);

    // R4, R5, R6, R7: all offsets from page-edge bases, branch taken
    for (int b = 0; b < 7; b++)
      for (int o = 0; o < 256; o++)
        runBranch(bases[b], 8'(o), 2'd0, 1'b1, 4'b0001, 1'b0);

    // R8 and R9: stalls with a competing start held high
    runBranch(16'h3010, 8'h05, 2'd1, 1'b1, 4'b0010, 1'b1);
    runBranch(16'h30F0, 8'h20, 2'd2, 1'b1, 4'b0100, 1'b1);
    runBranch(16'h3005, 8'hF0, 2'd3, 1'b1, 4'b1000, 1'b1);
    runBranch(16'h3005, 8'hF0, 2'd3, 1'b0, 4'b1000, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule